// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

A single peripheral DMA channel with two transfer descriptors, A and B, that take turns. Software programs one descriptor while the other is being moved, so a stream of buffers can run with no gap for reprogramming. The channel is set up through an eight-word register window. That window holds a configuration word, one control/status byte, and a start address and byte count for each descriptor. The control/status byte has no plain writable address. Software changes it through two aliases: one sets bits where a 1 is written, and the other clears bits where a 1 is written.

While the channel is enabled, it walks the descriptor selected by the buffer-select status bit. For each group of datums it presents one memory request, which holds an address and a beat count. The request stays up until the memory side acknowledges it. When a descriptor's count reaches zero, the channel marks that descriptor done and clears its armed bit. It then moves to the other descriptor if that one is armed. A level interrupt follows the done and error flags.

Top module: `dbdma_chan`

## Requirements
- R1: The register window uses word offsets 0 to 7:
  - 0: configuration, 32 bits, read back unchanged.
  - 1, 2 and 3: all read the status byte in bits 7:0, with zeros above.
  - 4: A start address. 5: A byte count. 6: B start address. 7: B byte count.
  - A byte count keeps only its low CNT_W bits (16 by default).
  - A write to offset 3 has no effect.
- R2: The status byte bits are:
  - 0: enable.
  - 1: interrupt enable.
  - 2: error.
  - 3: A done. 4: A armed.
  - 5: B done. 6: B armed.
  - 7: buffer select, where 1 means B is in use.

  Writing to offset 1 ORs the written low byte into the status byte. Writing to offset 2 clears every bit where the written low byte has a 1, so 0xFF clears the whole byte.
- R3: After reset:
  - the status byte and all other registers read 0;
  - `mem_req` is low;
  - `irq` is low.
- R4: The transfer is shaped by two configuration bits:
  - bit 3 gives the datum size (1 means 2 bytes, 0 means 1 byte);
  - bit 2 gives the burst length (1 means 8 datums, 0 means 4).

  Each request carries `beats` = min(burst length, remaining datums), where remaining datums = ceil(count / datum size). Each request's address follows on from the previous one. After the acknowledge, the descriptor's start address grows by `beats` × size. Its count falls by the same amount, and stops at 0 if it would go below.
- R5: When the active descriptor's count is 0, its armed bit clears and its done bit sets. The enable bit stays set.
- R6: Buffer selection works as follows:
  - With the select bit at 0 and both descriptors armed, A is moved before B.
  - When a descriptor finishes and the other one is armed, the select bit toggles.
  - When a descriptor finishes and the other one is not armed, the select bit is kept.
  - When the channel is idle, the current descriptor is not armed and the other one is armed, the select bit toggles before that descriptor runs.
- R7: A descriptor armed with a count of 0 completes without issuing any memory request.
- R8: With 2-byte datums, an odd current address has these effects:
  - the error bit sets and the enable bit clears;
  - the armed bit is kept;
  - no request is issued.

  The error bit holds until software clears it through offset 2.
- R9: `irq` equals interrupt-enable AND (A done OR B done OR error).
- R10: `mem_req` is raised only while the enable bit is set and the active descriptor is armed.
- R11: The request carries these configuration fields with it:
  - `mem_dev_rd` is configuration bit 0;
  - `mem_big_endian` is bit 1;
  - `mem_width2` is bit 3;
  - `dev_sel` is bits 7:4;
  - `dev_addr` is bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_addr | output | ADDR_W | Request start address |
| mem_beats | output | BEAT_W | Datums in this request |
| mem_ack | input | 1 | Request accepted on this clock edge |
| mem_dev_rd | output | 1 | Direction: 1 = read from device |
| mem_big_endian | output | 1 | Byte order of the device |
| mem_width2 | output | 1 | Datum size is 2 bytes |
| dev_sel | output | 4 | Device select field |
| dev_addr | output | 24 | Device address field |
| irq | output | 1 | Level interrupt |

## Verification
A wrong buffer-select or armed state appears at the memory port within one request. The request address then jumps to the wrong descriptor, or the order of A and B flips. The final status byte then shows the select bit at a value that R6 does not allow. A wrong count step appears on the next request as a beat count or address that breaks the ceil/min rule. It also appears at the end, when the count and address registers are read back. A missed error path appears within a few cycles of arming: the channel issues a request that should not exist, or it leaves the enable bit set.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int CSR_W = 8;

  localparam logic [2:0] OFS_CFG   = 3'd0;
  localparam logic [2:0] OFS_SET   = 3'd1;
  localparam logic [2:0] OFS_CLR   = 3'd2;
  localparam logic [2:0] OFS_STAT  = 3'd3;
  localparam logic [2:0] OFS_BUF0  = 3'd4;

  localparam int B_RUN   = 0;
  localparam int B_IE    = 1;
  localparam int B_ERROR = 2;
  localparam int B_DONEA = 3;
  localparam int B_STRTA = 4;
  localparam int B_DONEB = 5;
  localparam int B_STRTB = 6;
  localparam int B_BIU   = 7;

  typedef struct packed {
    logic [23:0] dev_addr;
    logic [3:0]  dev_sel;
    logic        wide;
    logic        long_burst;
    logic        big_end;
    logic        dev_rd;
  } cfg_t;

  typedef enum logic {ST_IDLE, ST_XFER} eng_state_e;

  function automatic int strt_bit(input int idx);
    return (idx != 0) ? B_STRTB : B_STRTA;
  endfunction

  function automatic int done_bit(input int idx);
    return (idx != 0) ? B_DONEB : B_DONEA;
  endfunction
endpackage

// File: rtl/dbdma_rst_sync.sv
module dbdma_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dbdma_regs.sv
module dbdma_regs
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [2:0]                   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [1:0]                   hw_done,
  input  logic                         hw_err,
  input  logic                         hw_toggle,
  input  logic                         adv_en,
  input  logic                         adv_idx,
  input  logic [ADDR_W-1:0]            adv_addr,
  input  logic [CNT_W-1:0]             adv_cnt,
  output logic [CSR_W-1:0]             csr,
  output cfg_t                         cfg,
  output logic [1:0][ADDR_W-1:0]       buf_addr,
  output logic [1:0][CNT_W-1:0]        buf_cnt
);
  logic [CSR_W-1:0] csr_d, csr_q;
  logic             csr_en;
  cfg_t             cfg_q;
  logic             cfg_en;
  logic             wr_set, wr_clr;

  assign wr_set = reg_we && (reg_addr == OFS_SET);
  assign wr_clr = reg_we && (reg_addr == OFS_CLR);
  assign cfg_en = reg_we && (reg_addr == OFS_CFG);

  // status next state: hardware events first, software aliases win
  always_comb begin
    csr_d = csr_q;
    for (int i = 0; i < 2; i++) begin
      if (hw_done[i]) begin
        csr_d[strt_bit(i)] = 1'b0;
        csr_d[done_bit(i)] = 1'b1;
      end
    end
    if (hw_err) begin
      csr_d[B_ERROR] = 1'b1;
      csr_d[B_RUN]   = 1'b0;
    end
    if (hw_toggle) csr_d[B_BIU] = ~csr_q[B_BIU];
    if (wr_set) csr_d = csr_d | reg_wdata[CSR_W-1:0];
    if (wr_clr) csr_d = csr_d & ~reg_wdata[CSR_W-1:0];
  end

  assign csr_en = wr_set || wr_clr || (|hw_done) || hw_err || hw_toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
      cfg_q <= '0;
    end else begin
      if (csr_en) csr_q <= csr_d;
      if (cfg_en) cfg_q <= cfg_t'(reg_wdata);
    end
  end

  assign csr = csr_q;
  assign cfg = cfg_q;

  for (genvar gi = 0; gi < 2; gi++) begin : g_buf
    localparam logic [2:0] OFS_S = OFS_BUF0 + 3'(2 * gi);
    localparam logic [2:0] OFS_C = OFS_BUF0 + 3'(2 * gi + 1);
    logic [ADDR_W-1:0] a_d, a_q;
    logic [CNT_W-1:0]  c_d, c_q;
    logic              a_en, c_en;
    logic              hw_hit;

    assign hw_hit = adv_en && (adv_idx == 1'(gi));

    always_comb begin
      a_d  = a_q;
      c_d  = c_q;
      a_en = 1'b0;
      c_en = 1'b0;
      if (hw_hit) begin
        a_d  = adv_addr;
        c_d  = adv_cnt;
        a_en = 1'b1;
        c_en = 1'b1;
      end
      if (reg_we && (reg_addr == OFS_S)) begin
        a_d  = reg_wdata[ADDR_W-1:0];
        a_en = 1'b1;
      end
      if (reg_we && (reg_addr == OFS_C)) begin
        c_d  = reg_wdata[CNT_W-1:0];
        c_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        c_q <= '0;
      end else begin
        if (a_en) a_q <= a_d;
        if (c_en) c_q <= c_d;
      end
    end

    assign buf_addr[gi] = a_q;
    assign buf_cnt[gi]  = c_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CFG:                   reg_rdata = cfg_q;
      OFS_SET, OFS_CLR, OFS_STAT: reg_rdata = 32'(csr_q);
      3'd4:                      reg_rdata = 32'(buf_addr[0]);
      3'd5:                      reg_rdata = 32'(buf_cnt[0]);
      3'd6:                      reg_rdata = 32'(buf_addr[1]);
      default:                   reg_rdata = 32'(buf_cnt[1]);
    endcase
  end
endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
  import dbdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8,
  localparam int BEAT_W     = $clog2(BURST_LONG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CSR_W-1:0]       csr,
  input  logic                   cfg_wide,
  input  logic                   cfg_long,
  input  logic [1:0][ADDR_W-1:0] buf_addr,
  input  logic [1:0][CNT_W-1:0]  buf_cnt,
  input  logic                   mem_ack,
  output logic [1:0]             hw_done,
  output logic                   hw_err,
  output logic                   hw_toggle,
  output logic                   adv_en,
  output logic                   adv_idx,
  output logic [ADDR_W-1:0]      adv_addr,
  output logic [CNT_W-1:0]       adv_cnt,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [BEAT_W-1:0]      mem_beats
);
  eng_state_e        st_q, st_d;
  logic              cur, run, cur_strt, oth_strt;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt, datums, burst_len, beats_full, bytes;
  logic              cnt_zero, misalign;

  assign cur      = csr[B_BIU];
  assign run      = csr[B_RUN];
  assign cur_strt = cur ? csr[B_STRTB] : csr[B_STRTA];
  assign oth_strt = cur ? csr[B_STRTA] : csr[B_STRTB];
  assign cur_addr = buf_addr[cur];
  assign cur_cnt  = buf_cnt[cur];
  assign cnt_zero = (cur_cnt == '0);
  assign misalign = cfg_wide && cur_addr[0];

  // datum and burst arithmetic for the next request
  assign datums     = cfg_wide ? ((cur_cnt >> 1) + CNT_W'(cur_cnt[0])) : cur_cnt;
  assign burst_len  = cfg_long ? CNT_W'(BURST_LONG) : CNT_W'(BURST_SHORT);
  assign beats_full = (datums < burst_len) ? datums : burst_len;
  assign bytes      = cfg_wide ? {beats_full[CNT_W-2:0], 1'b0} : beats_full;

  assign adv_idx  = cur;
  assign adv_addr = cur_addr + ADDR_W'(bytes);
  assign adv_cnt  = (cur_cnt > bytes) ? (cur_cnt - bytes) : '0;

  always_comb begin
    st_d      = st_q;
    hw_done   = 2'b00;
    hw_err    = 1'b0;
    hw_toggle = 1'b0;
    adv_en    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (run) begin
          if (cur_strt) begin
            st_d = ST_XFER;
          end else if (oth_strt) begin
            hw_toggle = 1'b1;
            st_d      = ST_XFER;
          end
        end
      end
      default: begin
        if (run) begin
          if (!cur_strt) begin
            st_d = ST_IDLE;
          end else if (cnt_zero) begin
            hw_done[cur] = 1'b1;
            hw_toggle    = oth_strt;
            st_d         = ST_IDLE;
          end else if (misalign) begin
            hw_err = 1'b1;
            st_d   = ST_IDLE;
          end else if (mem_ack) begin
            adv_en = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign mem_req   = (st_q == ST_XFER) && run && cur_strt && !cnt_zero && !misalign;
  assign mem_addr  = cur_addr;
  assign mem_beats = beats_full[BEAT_W-1:0];
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8,
  localparam int BEAT_W     = $clog2(BURST_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] mem_beats,
  input  logic              mem_ack,
  output logic              mem_dev_rd,
  output logic              mem_big_endian,
  output logic              mem_width2,
  output logic [3:0]        dev_sel,
  output logic [23:0]       dev_addr,
  output logic              irq
);
  logic                   rst_n_s;
  logic [CSR_W-1:0]       csr;
  cfg_t                   cfg;
  logic [1:0][ADDR_W-1:0] buf_addr;
  logic [1:0][CNT_W-1:0]  buf_cnt;
  logic [1:0]             hw_done;
  logic                   hw_err, hw_toggle, adv_en, adv_idx;
  logic [ADDR_W-1:0]      adv_addr;
  logic [CNT_W-1:0]       adv_cnt;

  dbdma_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dbdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_done(hw_done), .hw_err(hw_err), .hw_toggle(hw_toggle),
    .adv_en(adv_en), .adv_idx(adv_idx), .adv_addr(adv_addr), .adv_cnt(adv_cnt),
    .csr(csr), .cfg(cfg), .buf_addr(buf_addr), .buf_cnt(buf_cnt)
  );

  dbdma_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG)
  ) u_eng (
    .clk(clk), .rst_n(rst_n_s),
    .csr(csr), .cfg_wide(cfg.wide), .cfg_long(cfg.long_burst),
    .buf_addr(buf_addr), .buf_cnt(buf_cnt), .mem_ack(mem_ack),
    .hw_done(hw_done), .hw_err(hw_err), .hw_toggle(hw_toggle),
    .adv_en(adv_en), .adv_idx(adv_idx), .adv_addr(adv_addr), .adv_cnt(adv_cnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_beats(mem_beats)
  );

  assign mem_dev_rd     = cfg.dev_rd;
  assign mem_big_endian = cfg.big_end;
  assign mem_width2     = cfg.wide;
  assign dev_sel        = cfg.dev_sel;
  assign dev_addr       = cfg.dev_addr;

  assign irq = csr[B_IE] && (csr[B_DONEA] || csr[B_DONEB] || csr[B_ERROR]);
endmodule

// File: rtl/dbdma_chk.sv
module dbdma_chk
  import dbdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BURST_LONG = 8,
  parameter int BEAT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [CSR_W-1:0]  csr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BEAT_W-1:0] mem_beats,
  input logic              mem_width2
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_we |=> mem_req && $stable(mem_addr) && $stable(mem_beats));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> csr[B_RUN] && (csr[B_STRTA] || csr[B_STRTB]));

  // R4
  beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_beats != '0) && (32'(mem_beats) <= BURST_LONG));

  // R8
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_width2 |-> !mem_addr[0]);

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr[B_ERROR]) && !$past(reg_we) |-> !csr[B_RUN]);

  // R5
  done_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr[B_DONEA]) && !$past(reg_we) |-> !csr[B_STRTA] && $past(csr[B_STRTA]));
endmodule

bind dbdma_chan dbdma_chk #(.ADDR_W(ADDR_W), .BURST_LONG(BURST_LONG), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .csr(csr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_beats(mem_beats), .mem_width2(mem_width2)
);

// File: tb/dbdma_chan_test.sv
module dbdma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr;
  logic [3:0]  mem_beats;
  logic        mem_dev_rd, mem_big_endian, mem_width2;
  logic [3:0]  dev_sel;
  logic [23:0] dev_addr;
  logic        irq;

  always #2 clk = ~clk;

  dbdma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_beats(mem_beats), .mem_ack(mem_ack),
    .mem_dev_rd(mem_dev_rd), .mem_big_endian(mem_big_endian),
    .mem_width2(mem_width2), .dev_sel(dev_sel), .dev_addr(dev_addr), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  // bench-side expectation of the memory stream
  logic [31:0] m_ptr [2];
  int          m_rem [2];
  int          m_w, m_burst;
  logic [3:0]  m_sel;
  logic        m_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int f_beats(input int rem, input int w, input int burst);
    int d;
    d = w ? (rem + 1) / 2 : rem;
    return (d < burst) ? d : burst;
  endfunction

  function automatic int f_bytes(input int cnt, input int w);
    return w ? ((cnt + 1) / 2) * 2 : cnt;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, s);
      if ((s & 32'h50) == 0) break;
    end
  endtask

  // memory responder with a stream check against the expectation (R4, R11, R10)
  initial begin
    int idx;
    int b;
    mem_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req && ($urandom % 3 != 0)) begin
        idx = 0;
        while (idx < 2 && m_rem[idx] == 0) idx++;
        if (idx == 2) begin
          chk("R10 unexpected request addr", mem_addr, 32'hffffffff);
        end else begin
          b = f_beats(m_rem[idx], m_w, m_burst);
          chk("R4 request address", mem_addr, m_ptr[idx]);
          chk("R4 request beats", 32'(mem_beats), 32'(b));
          chk("R11 sideband", {26'd0, mem_width2, mem_dev_rd, dev_sel},
              {26'd0, 1'(m_w), m_rd, m_sel});
          m_ptr[idx] = m_ptr[idx] + 32'(b * (m_w ? 2 : 1));
          m_rem[idx] = m_rem[idx] - b * (m_w ? 2 : 1);
          if (m_rem[idx] < 0) m_rem[idx] = 0;
        end
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic run_xfer(input int w, input int lng, input int ie,
                          input logic [31:0] a_a, input int c_a,
                          input logic [31:0] a_b, input int c_b,
                          input int arm_a, input int arm_b);
    logic [31:0] s, cfgw;
    logic [7:0]  exp_s;
    logic [3:0]  sel;
    sel = 4'($urandom);
    cfgw = {24'h00abc0 + 24'($urandom % 16), sel, 1'(w), 1'(lng), 1'b0, 1'(arm_a)};
    wr(3'd2, 32'hff);
    wr(3'd0, cfgw);
    wr(3'd4, a_a); wr(3'd5, 32'(c_a));
    wr(3'd6, a_b); wr(3'd7, 32'(c_b));
    m_w = w; m_burst = lng ? 8 : 4; m_sel = sel; m_rd = 1'(arm_a);
    m_ptr[0] = a_a; m_ptr[1] = a_b;
    m_rem[0] = arm_a ? c_a : 0;
    m_rem[1] = arm_b ? c_b : 0;
    wr(3'd1, 32'h1 | (ie ? 32'h2 : 0) | (arm_a ? 32'h10 : 0) | (arm_b ? 32'h40 : 0));
    wait_idle();
    rd(3'd3, s);
    // R5, R6: both done, run kept, select bit ends at 1 exactly when B was armed
    exp_s = 8'h01 | (ie ? 8'h02 : 8'h00) | (arm_a ? 8'h08 : 8'h00) |
            (arm_b ? 8'h20 : 8'h00) | (arm_b ? 8'h80 : 8'h00);
    chk("R5 R6 final status", s, 32'(exp_s));
    chk("R9 irq level", 32'(irq), 32'(ie && (arm_a || arm_b)));
    chk("R4 stream consumed", 32'(m_rem[0] + m_rem[1]), 32'd0);
    if (arm_a) begin
      rd(3'd5, s); chk("R4 A count zero", s, 32'd0);
      rd(3'd4, s); chk("R4 A address advanced", s, a_a + 32'(f_bytes(c_a, w)));
    end
    if (arm_b) begin
      rd(3'd7, s); chk("R4 B count zero", s, 32'd0);
      rd(3'd6, s); chk("R4 B address advanced", s, a_b + 32'(f_bytes(c_b, w)));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd1234));
    m_rem[0] = 0; m_rem[1] = 0; m_w = 0; m_burst = 4; m_sel = 0; m_rd = 0;
    m_ptr[0] = 0; m_ptr[1] = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    rd(3'd3, s); chk("R3 status after reset", s, 32'd0);
    rd(3'd5, s); chk("R3 A count after reset", s, 32'd0);
    chk("R3 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R3 irq after reset", 32'(irq), 32'd0);

    // R1 register map
    wr(3'd0, 32'hdeadbe35); rd(3'd0, s); chk("R1 cfg readback", s, 32'hdeadbe35);
    chk("R11 dev_addr field", 32'(dev_addr), 32'h00deadbe);
    chk("R11 dev_sel/flags", {26'd0, dev_sel, mem_big_endian, mem_dev_rd}, {26'd0, 4'h3, 1'b0, 1'b1});
    wr(3'd4, 32'h12345678); rd(3'd4, s); chk("R1 A start readback", s, 32'h12345678);
    wr(3'd7, 32'habcd1234); rd(3'd7, s); chk("R1 B count truncated", s, 32'h00001234);
    wr(3'd3, 32'hff); rd(3'd3, s); chk("R1 write to status read ignored", s, 32'd0);

    // R2 set and clear aliases
    wr(3'd1, 32'h82); rd(3'd1, s); chk("R2 set alias", s, 32'h82);
    wr(3'd2, 32'h02); rd(3'd2, s); chk("R2 clear alias", s, 32'h80);
    wr(3'd1, 32'h0a); chk("R9 irq from done", 32'(irq), 32'd1);
    wr(3'd2, 32'h08); chk("R9 irq drops", 32'(irq), 32'd0);
    wr(3'd2, 32'hff); rd(3'd3, s); chk("R2 clear all", s, 32'd0);

    // R7 zero counts complete without requests
    run_xfer(0, 0, 1, 32'h100, 0, 32'h200, 0, 1, 1);
    // R6 single A keeps select at 0, then lone B toggles it
    run_xfer(1, 1, 1, 32'h1000, 20, 32'h2000, 6, 1, 0);
    run_xfer(0, 0, 0, 32'h1000, 5, 32'h3001, 13, 0, 1);
    // R4 odd byte count with 2-byte datums, long burst
    run_xfer(1, 1, 1, 32'h4000, 33, 32'h5000, 17, 1, 1);

    // random transfers (R4, R5, R6, R9)
    for (int k = 0; k < 10; k++) begin
      int w, lng, ca, cb;
      w = $urandom % 2; lng = $urandom % 2;
      ca = $urandom % 41; cb = $urandom % 41;
      run_xfer(w, lng, $urandom % 2,
               32'h1000_0000 + 32'(($urandom % 256) * 4), ca,
               32'h2000_0000 + 32'(($urandom % 256) * 4), cb,
               $urandom % 2, $urandom % 2);
    end

    // R8 misaligned 2-byte transfer
    wr(3'd2, 32'hff);
    wr(3'd0, 32'h8);
    wr(3'd4, 32'h0000_1001); wr(3'd5, 32'd4);
    m_w = 1; m_rem[0] = 0; m_rem[1] = 0;
    wr(3'd1, 32'h13);
    repeat (10) @(negedge clk);
    rd(3'd3, s); chk("R8 error set, run cleared, armed kept", s, 32'h16);
    chk("R9 irq on error", 32'(irq), 32'd1);
    repeat (20) @(negedge clk);
    rd(3'd3, s); chk("R8 error holds", s, 32'h16);
    rd(3'd5, s); chk("R8 count untouched", s, 32'd4);
    wr(3'd2, 32'h04);
    rd(3'd3, s); chk("R8 error cleared by alias", s, 32'h12);
    chk("R9 irq after error clear", 32'(irq), 32'd0);
    wr(3'd2, 32'hff);

    repeat (4) @(negedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule